// File: doc/BRIEF.md
# Raster timing generator with border regions

This block produces the horizontal and vertical scan timing for a display output stage. A pixel counter sweeps each line and a line counter sweeps each frame. Along each axis the position falls into six phases in a fixed order: sync pulse, back porch, leading border, active display, trailing border and front porch. The counter then wraps at the programmed total. The block drives both sync pulses, a display-enable, a border-enable and the current pixel and line positions. The border is a region of its own on both sides of the active area on each axis, kept apart from blanking.

Software sets every phase boundary as an explicit start position over a plain 32-bit write bus. It also sets the sync polarities and a run/stop bit. Timing writes land in a pending copy. That copy moves into the working copy at the end of a frame, or at once while the generator is stopped, so a mode change never tears a frame. Working out border widths from mode parameters is left to software.

Top module: `raster_timing_gen`

## Requirements
- R1: Register map, as word addresses on `wr_addr`. Address 0 is horizontal total in [11:0] and sync width (back-porch start) in [27:16]. Address 1 is horizontal leading-border start in [11:0] and display start in [27:16]. Address 2 is horizontal trailing-border start in [11:0] and front-porch start in [27:16]. Addresses 3, 4 and 5 hold the same fields for the vertical axis. Address 6 is control: bit 31 run, bit 1 horizontal polarity, bit 3 vertical polarity. All other bits of every word are ignored.
- R2: While running, `pix_x` counts 0 to total-1 and wraps to 0. `line_y` advances by one on each pixel wrap and wraps to 0 after line total-1.
- R3: A sync is asserted while its axis position is below that axis's back-porch start. A polarity bit of 1 gives an active-high pulse and a bit of 0 gives an active-low pulse.
- R4: `de` is 1 exactly when both positions lie in [display start, trailing-border start).
- R5: `border` is 1 when both positions lie in [leading-border start, front-porch start) and `de` is 0. `de` and `border` are never 1 together.
- R6: Stopping (bit 31 cleared) forces `pix_x`=0, `line_y`=0, `de`=0, `border`=0 and each sync to its inactive level, from the second rising edge after the write.
- R7: Starting (bit 31 set) shows position (0,0) from the second rising edge after the write, then advances one pixel per clock.
- R8: Timing writes made while running take effect from the first pixel of the next frame. Writes made while stopped take effect for the next start.
- R9: After reset the generator is stopped, both polarities are active-low, both syncs are 1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity per control bit 1 |
| vsync_o | output | 1 | Vertical sync, polarity per control bit 3 |
| de_o | output | 1 | Display enable |
| border_o | output | 1 | Border enable |
| pix_x_o | output | 12 | Current pixel position |
| line_y_o | output | 12 | Current line position |

## Verification
A control write is registered at the first rising edge and changes the outputs at the second. The bench therefore samples the first stop or start result at the falling edge after that second edge. All outputs are registered together from one counter state, so position, syncs and enables always describe the same pixel. The bench predicts each sample by arithmetic from the position it expects. It switches its model to new timing only when it wraps past the last pixel of a frame, which matches the edge at which the pending copy loads.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  parameter int unsigned RTG_CW = 12;   // counter and field width
  localparam int unsigned FLD_LO = 0;   // low field position
  localparam int unsigned FLD_HI = 16;  // high field position
  localparam int unsigned BIT_RUN = 31;
  localparam int unsigned BIT_HPOL = 1;
  localparam int unsigned BIT_VPOL = 3;

  localparam int unsigned RA_H_TOT = 0;
  localparam int unsigned RA_H_BRD = 1;
  localparam int unsigned RA_H_END = 2;
  localparam int unsigned RA_V_TOT = 3;
  localparam int unsigned RA_V_BRD = 4;
  localparam int unsigned RA_V_END = 5;
  localparam int unsigned RA_CTRL  = 6;

  typedef enum logic [2:0] {
    PH_SYNC, PH_BACK, PH_LEAD, PH_ACT, PH_TRAIL, PH_FRONT
  } phase_e;

  typedef struct packed {
    logic [RTG_CW-1:0] tot;
    logic [RTG_CW-1:0] bp;
    logic [RTG_CW-1:0] lead;
    logic [RTG_CW-1:0] disp;
    logic [RTG_CW-1:0] trail;
    logic [RTG_CW-1:0] front;
  } axis_cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              load,
  output axis_cfg_t         h_act,
  output axis_cfg_t         v_act,
  output logic              run,
  output logic              hpol,
  output logic              vpol
);
  axis_cfg_t h_pend, v_pend;
  logic [RTG_CW-1:0] f_lo, f_hi;

  assign f_lo = wr_data[FLD_LO +: RTG_CW];
  assign f_hi = wr_data[FLD_HI +: RTG_CW];

  wire unused_wr_bits = ^{wr_data[30:28], wr_data[15:12], wr_data[2], wr_data[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      h_pend <= '0;
      v_pend <= '0;
      run    <= 1'b0;
      hpol   <= 1'b0;
      vpol   <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(RA_H_TOT)) begin h_pend.tot   <= f_lo; h_pend.bp    <= f_hi; end
      if (wr_addr == ADDR_W'(RA_H_BRD)) begin h_pend.lead  <= f_lo; h_pend.disp  <= f_hi; end
      if (wr_addr == ADDR_W'(RA_H_END)) begin h_pend.trail <= f_lo; h_pend.front <= f_hi; end
      if (wr_addr == ADDR_W'(RA_V_TOT)) begin v_pend.tot   <= f_lo; v_pend.bp    <= f_hi; end
      if (wr_addr == ADDR_W'(RA_V_BRD)) begin v_pend.lead  <= f_lo; v_pend.disp  <= f_hi; end
      if (wr_addr == ADDR_W'(RA_V_END)) begin v_pend.trail <= f_lo; v_pend.front <= f_hi; end
      if (wr_addr == ADDR_W'(RA_CTRL)) begin
        run  <= wr_data[BIT_RUN];
        hpol <= wr_data[BIT_HPOL];
        vpol <= wr_data[BIT_VPOL];
      end
    end
  end

  // working copy follows the pending copy only when told to
  always_ff @(posedge clk) begin
    if (rst) begin
      h_act <= '0;
      v_act <= '0;
    end else if (load) begin
      h_act <= h_pend;
      v_act <= v_pend;
    end
  end
endmodule

// File: rtl/rtg_phase.sv
module rtg_phase
  import rtg_pkg::*;
(
  input  axis_cfg_t         cfg,
  input  logic [RTG_CW-1:0] pos,
  output phase_e            ph
);
  always_comb begin
    if (pos < cfg.bp)         ph = PH_SYNC;
    else if (pos < cfg.lead)  ph = PH_BACK;
    else if (pos < cfg.disp)  ph = PH_LEAD;
    else if (pos < cfg.trail) ph = PH_ACT;
    else if (pos < cfg.front) ph = PH_TRAIL;
    else                      ph = PH_FRONT;
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              border_o,
  output logic [RTG_CW-1:0] pix_x_o,
  output logic [RTG_CW-1:0] line_y_o
);
  localparam int NAX = 2;  // axis 0 horizontal, axis 1 vertical

  axis_cfg_t h_act, v_act;
  logic run, hpol, vpol;
  logic [RTG_CW-1:0] hcnt, vcnt;
  logic h_last, v_last, frame_end, load;

  axis_cfg_t         cfg_a [NAX];
  logic [RTG_CW-1:0] pos_a [NAX];
  phase_e            ph_a  [NAX];
  logic              win_a [NAX];
  logic              act_a [NAX];

  assign h_last    = ({1'b0, hcnt} + (RTG_CW+1)'(1)) >= {1'b0, h_act.tot};
  assign v_last    = ({1'b0, vcnt} + (RTG_CW+1)'(1)) >= {1'b0, v_act.tot};
  assign frame_end = run && h_last && v_last;
  assign load      = !run || frame_end;

  rtg_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(load), .h_act(h_act), .v_act(v_act), .run(run), .hpol(hpol), .vpol(vpol)
  );

  assign cfg_a[0] = h_act;
  assign cfg_a[1] = v_act;
  assign pos_a[0] = hcnt;
  assign pos_a[1] = vcnt;

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    rtg_phase u_ph (.cfg(cfg_a[a]), .pos(pos_a[a]), .ph(ph_a[a]));
    assign win_a[a] = (ph_a[a] == PH_LEAD) || (ph_a[a] == PH_ACT) || (ph_a[a] == PH_TRAIL);
    assign act_a[a] = (ph_a[a] == PH_ACT);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_x_o  <= '0;
      line_y_o <= '0;
      hsync_o  <= 1'b1;
      vsync_o  <= 1'b1;
      de_o     <= 1'b0;
      border_o <= 1'b0;
    end else if (!run) begin
      pix_x_o  <= '0;
      line_y_o <= '0;
      hsync_o  <= !hpol;
      vsync_o  <= !vpol;
      de_o     <= 1'b0;
      border_o <= 1'b0;
    end else begin
      pix_x_o  <= hcnt;
      line_y_o <= vcnt;
      hsync_o  <= (ph_a[0] == PH_SYNC) ? hpol : !hpol;
      vsync_o  <= (ph_a[1] == PH_SYNC) ? vpol : !vpol;
      de_o     <= act_a[0] && act_a[1];
      border_o <= win_a[0] && win_a[1] && !(act_a[0] && act_a[1]);
    end
  end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              hpol,
  input logic              hsync_o,
  input logic              de_o,
  input logic              border_o,
  input logic [RTG_CW-1:0] pix_x_o,
  input logic [RTG_CW-1:0] line_y_o
);
  assert_stop_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pix_x_o == '0 && line_y_o == '0 && !de_o && !border_o && hsync_o == !$past(hpol)));

  assert_x_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $past(run, 2) && $past(run, 3) && pix_x_o != '0)
      |-> pix_x_o == $past(pix_x_o) + 1'b1);

  assert_y_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (run && $past(run) && $past(run, 2) && $past(run, 3) && pix_x_o != '0)
      |-> $stable(line_y_o));

  assert_de_running_R4: assert property (@(posedge clk) disable iff (rst)
    de_o |-> $past(run));

  assert_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(de_o && border_o));
endmodule

bind raster_timing_gen rtg_checker u_chk (
  .clk(clk), .rst(rst), .run(run), .hpol(hpol), .hsync_o(hsync_o),
  .de_o(de_o), .border_o(border_o), .pix_x_o(pix_x_o), .line_y_o(line_y_o)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic hsync_o, vsync_o, de_o, border_o;
  logic [11:0] pix_x_o, line_y_o;

  int total = 0, bad = 0;
  bit chk_on = 1'b0;
  int ex = 0, ey = 0;
  bit hp_m = 0, vp_m = 0;
  int h_cur[6], v_cur[6], h_pend[6], v_pend[6];

  always #5 clk = ~clk;

  raster_timing_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .border_o(border_o),
    .pix_x_o(pix_x_o), .line_y_o(line_y_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)", tag, act, exp, ex, ey);
    end
  endtask

  // phase index: 0 sync,1 back,2 lead,3 active,4 trail,5 front
  function automatic int ph(input int p, input int c[6]);
    if (p < c[1]) return 0;
    if (p < c[2]) return 1;
    if (p < c[3]) return 2;
    if (p < c[4]) return 3;
    if (p < c[5]) return 4;
    return 5;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // junk in bits 12-15 and 28-30 must be ignored (R1)
  task automatic prog(input int h[6], input int v[6]);
    h_pend = h; v_pend = v;
    wr(0, 32'h7000_F000 | 32'(h[0]) | (32'(h[1]) << 16));
    wr(1, 32'h7000_F000 | 32'(h[2]) | (32'(h[3]) << 16));
    wr(2, 32'h7000_F000 | 32'(h[4]) | (32'(h[5]) << 16));
    wr(3, 32'h7000_F000 | 32'(v[0]) | (32'(v[1]) << 16));
    wr(4, 32'h7000_F000 | 32'(v[2]) | (32'(v[3]) << 16));
    wr(5, 32'h7000_F000 | 32'(v[4]) | (32'(v[5]) << 16));
  endtask

  task automatic start(input bit hp, input bit vp);
    wr(6, 32'h8000_0050 | (32'(hp) << 1) | (32'(vp) << 3));
    #1;
    hp_m = hp; vp_m = vp; ex = 0; ey = 0;
    h_cur = h_pend; v_cur = v_pend;
    chk_on = 1'b1;   // R7: first sample at next falling edge is (0,0)
  endtask

  task automatic stop_and_check(input bit hp, input bit vp);
    #1 chk_on = 1'b0;
    wr(6, 32'h0000_0005 | (32'(hp) << 1) | (32'(vp) << 3));
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(pix_x_o == 0 && line_y_o == 0, "R6 idle position", pix_x_o, 0);
      chk(hsync_o == !hp, "R6 idle hsync", hsync_o, !hp);
      chk(vsync_o == !vp, "R6 idle vsync", vsync_o, !vp);
      chk(!de_o && !border_o, "R6 idle enables", {de_o, border_o}, 0);
    end
  endtask

  // running model, one sample per falling edge
  initial forever begin
    @(negedge clk);
    if (chk_on) begin
      int hph, vph;
      hph = ph(ex, h_cur);
      vph = ph(ey, v_cur);
      chk(pix_x_o == 12'(ex), "R2 pixel position", pix_x_o, ex);
      chk(line_y_o == 12'(ey), "R2 line position", line_y_o, ey);
      chk(hsync_o == ((hph == 0) ? hp_m : !hp_m), "R3 hsync", hsync_o, (hph == 0) ? hp_m : !hp_m);
      chk(vsync_o == ((vph == 0) ? vp_m : !vp_m), "R3 vsync", vsync_o, (vph == 0) ? vp_m : !vp_m);
      chk(de_o == (hph == 3 && vph == 3), "R4 display enable", de_o, (hph == 3 && vph == 3));
      chk(border_o == (hph >= 2 && hph <= 4 && vph >= 2 && vph <= 4 && !(hph == 3 && vph == 3)),
          "R5 border enable", border_o,
          (hph >= 2 && hph <= 4 && vph >= 2 && vph <= 4 && !(hph == 3 && vph == 3)));
      if (ex + 1 >= h_cur[0]) begin
        ex = 0;
        if (ey + 1 >= v_cur[0]) begin
          ey = 0;
          h_cur = h_pend; v_cur = v_pend;   // R8 frame boundary
        end else ey++;
      end else ex++;
    end
  end

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ha[6] = '{20, 2, 4, 6, 14, 16};
    int va[6] = '{10, 1, 2, 3, 7, 8};
    int hb[6] = '{16, 1, 3, 4, 12, 13};   // lead border width 1
    int vb[6] = '{8, 2, 3, 3, 6, 7};      // no leading border
    int hc[6] = '{12, 1, 2, 3, 9, 10};
    int vc[6] = '{6, 1, 1, 2, 5, 5};      // no back porch, no trailing border
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(hsync_o && vsync_o, "R9 reset syncs", {hsync_o, vsync_o}, 3);
    chk(!de_o && !border_o, "R9 reset enables", {de_o, border_o}, 0);
    chk(pix_x_o == 0 && line_y_o == 0, "R9 reset position", pix_x_o, 0);
    repeat (4) @(negedge clk);
    chk(hsync_o && pix_x_o == 0, "R9 stays stopped", pix_x_o, 0);

    prog(ha, va);                 // R1, R8 while stopped
    start(1'b1, 1'b0);
    repeat (290) @(negedge clk);
    while (ey != 4) @(negedge clk);
    prog(hb, vb);                 // R8 mid-frame write
    repeat (350) @(negedge clk);
    stop_and_check(1'b1, 1'b0);

    prog(hc, vc);
    start(1'b0, 1'b1);
    repeat (160) @(negedge clk);
    stop_and_check(1'b0, 1'b1);

    start(1'b1, 1'b1);
    repeat (80) @(negedge clk);
    stop_and_check(1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule